// File: doc/BRIEF.md
# Packet FIFO with Start-of-Cell Marking

This block is a single-clock FIFO for a byte stream cut into fixed-length cells of 53 bytes. Each byte is stored together with one extra marker bit, so each stored word is 9 bits wide. The write side counts accepted bytes and sets the marker on the byte that opens a cell. Cell boundaries therefore travel through the queue inside the data words, and no separate boundary queue is needed.

On the read side each byte comes out with a start-of-cell indication taken from the stored marker. A small checker on the output counts the spacing between marked words and raises a sticky error if a marker comes early, comes late or is missing. Writes to a full queue are dropped and set a sticky overflow flag. Reads from an empty queue have no effect.

Top module: `pkt_fifo`

## Requirements
- R1: Accepted bytes come out on `rd_byte` in the order they were written, with their values unchanged.
- R2: After reset, the first accepted byte is read out with `rd_sop` = 1.
- R3: `rd_sop` is 1 exactly on the bytes whose index among accepted writes since reset is a multiple of CELL_LEN (53), counting from 0. The byte at index 52 carries 0 and the byte at index 53 carries 1.
- R4: A write while `full` = 1 is dropped. It does not advance the cell byte count, and it sets `overflow`. Once set, `overflow` stays at 1 until reset.
- R5: A read request while `empty` = 1 is ignored. `rd_valid` stays 0 in the following cycle, and no stored byte is lost.
- R6: `full` is 1 exactly when 2**ADDR_W bytes are held. `empty` is 1 exactly when no bytes are held. The two are never 1 together.
- R7: A read request accepted at a clock edge makes `rd_valid` = 1 after that same edge, with the byte and its marker on `rd_byte` and `rd_sop`. `rd_valid` is 0 in every other cycle.
- R8: `frame_err` becomes 1 and stays 1 if a delivered word's `rd_sop` does not match the word's position in the output stream, where a marker is expected every CELL_LEN words. For a stream written through this block, `frame_err` stays 0.
- R9: Active-low synchronous reset empties the queue and clears `overflow`, `frame_err`, `rd_valid` and the cell byte counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request for `wr_byte` |
| wr_byte | input | 8 | Byte to store |
| full | output | 1 | Queue holds 2**ADDR_W bytes |
| overflow | output | 1 | Sticky: a write was dropped |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | `rd_byte` and `rd_sop` carry a delivered word |
| rd_byte | output | 8 | Delivered byte |
| rd_sop | output | 1 | Delivered byte opens a cell |
| empty | output | 1 | Queue holds no bytes |
| frame_err | output | 1 | Sticky: marker spacing broken on the output |

## Verification
The assertions check, on every cycle, the invariants that do not depend on history. The write-side counter stays in range and wraps after the last byte of a cell. A rejected write sets overflow and leaves the write pointer still. A rejected read yields no valid word. Full and empty are exclusive, overflow stays set once raised, and frame_err stays clear. Only the bench scenarios can show that bytes arrive in order with the right values, that markers fall on multiples of 53 across queue wrap-around and dropped writes, and that the queue reports full and empty at the exact fill levels.

// File: rtl/pkt_fifo_pkg.sv
// Shared types for the packet FIFO: one stored word is a byte plus a start-of-cell marker.
package pkt_fifo_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              sop;
        logic [BYTE_W-1:0] data;
    } cell_word_t;
endpackage

// File: rtl/cell_marker.sv
// cell_marker: counts accepted write bytes modulo CELL_LEN and raises `first`
// when the next accepted byte opens a cell. Assumes `accept` is high only for
// bytes that actually enter storage.
module cell_marker #(
    parameter int CELL_LEN = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic first
);
    localparam int CW = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);

    logic [CW-1:0] pos;

    // Advance the byte position on each accepted byte and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (accept)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end

    assign first = (pos == '0);

    // R3: position never leaves the cell range
    a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    // R3: after the last byte of a cell the next byte is marked
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pos == LAST) |=> first);
endmodule

// File: rtl/fifo_store.sv
// fifo_store: circular buffer of 2**ADDR_W words, with pointers carrying a wrap bit.
// The read word is registered, so it is valid one edge after an accepted read.
// Assumes requests may arrive in any cycle. Illegal requests are filtered here.
module fifo_store
    import pkt_fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  cell_word_t wr_word,
    output logic       wr_accept,
    input  logic       rd_req,
    output cell_word_t rd_word,
    output logic       rd_valid,
    output logic       full,
    output logic       empty,
    output logic       overflow
);
    localparam int DEPTH = 1 << ADDR_W;

    cell_word_t        mem [DEPTH];
    logic [ADDR_W:0]   wp, rp;
    logic              rd_accept;

    assign empty     = (wp == rp);
    assign full      = (wp[ADDR_W] != rp[ADDR_W]) && (wp[ADDR_W-1:0] == rp[ADDR_W-1:0]);
    assign wr_accept = wr_req && !full;
    assign rd_accept = rd_req && !empty;

    // Store an accepted word at the write address.
    always_ff @(posedge clk) begin
        if (wr_accept)
            mem[wp[ADDR_W-1:0]] <= wr_word;
    end

    // Move the pointers, register the read word and track dropped writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            rd_valid <= 1'b0;
            rd_word  <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_accept) wp <= wp + 1'b1;
            if (rd_accept) begin
                rp      <= rp + 1'b1;
                rd_word <= mem[rp[ADDR_W-1:0]];
            end
            rd_valid <= rd_accept;
            if (wr_req && full) overflow <= 1'b1;
        end
    end

    // R4: a write against a full queue is dropped and flagged
    a_r4_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full) |=> (overflow && $stable(wp)));
    // R4: overflow is sticky
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R5: a read against an empty queue yields nothing
    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> (!rd_valid && $stable(rp)));
    // R6: full and empty never coincide
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R7: an accepted read delivers a word after the edge
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !empty) |=> rd_valid);
endmodule

// File: rtl/frame_check.sv
// frame_check: follows the delivered word stream and expects a marker exactly
// every CELL_LEN words, starting with the first word after reset. Any mismatch
// sets a sticky error.
module frame_check #(
    parameter int CELL_LEN = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic sop,
    output logic err
);
    localparam int CW = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);

    logic [CW-1:0] pos;

    // Compare each delivered marker with the expected position, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            err <= 1'b0;
        end else if (valid) begin
            if (sop != (pos == '0)) err <= 1'b1;
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/pkt_fifo.sv
// pkt_fifo: byte FIFO that stores a start-of-cell marker beside each byte.
// Assumes fixed CELL_LEN-byte cells that start with the first byte after reset.
module pkt_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int CELL_LEN = 53,
    parameter int ADDR_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              full,
    output logic              overflow,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_sop,
    output logic              empty,
    output logic              frame_err
);
    logic       wr_accept;
    logic       mark_first;
    cell_word_t in_word, out_word;

    // Attach the marker to the byte being written.
    always_comb begin
        in_word.sop  = mark_first;
        in_word.data = wr_byte;
    end

    cell_marker #(.CELL_LEN(CELL_LEN)) u_marker (
        .clk(clk), .rst_n(rst_n), .accept(wr_accept), .first(mark_first)
    );

    fifo_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_valid), .wr_word(in_word), .wr_accept(wr_accept),
        .rd_req(rd_en), .rd_word(out_word), .rd_valid(rd_valid),
        .full(full), .empty(empty), .overflow(overflow)
    );

    assign rd_byte = out_word.data;
    assign rd_sop  = out_word.sop;

    frame_check #(.CELL_LEN(CELL_LEN)) u_check (
        .clk(clk), .rst_n(rst_n), .valid(rd_valid), .sop(rd_sop), .err(frame_err)
    );

    // R8: a stream marked by this block never breaks the spacing
    a_r8_no_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_err);
endmodule

// File: tb/tb_pkt_fifo.sv
`timescale 1ns/1ps
module tb_pkt_fifo;
    localparam int CELL = 53;
    localparam int AW   = 4;
    localparam int DEP  = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       full, overflow, rd_valid, rd_sop, empty, frame_err;

    always #2.5 clk = ~clk;

    pkt_fifo #(.CELL_LEN(CELL), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .full(full), .overflow(overflow), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .rd_sop(rd_sop), .empty(empty), .frame_err(frame_err)
    );
    logic [7:0] rd_byte;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [8:0] q[$];
    int  wcount = 0;
    bit  exp_ovf = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: sample at the falling edge, drive, pass the rising edge, check.
    task automatic cyc(input bit w, input logic [7:0] b, input bit r);
        bit acc_w, acc_r;
        logic [8:0] exp_word;
        chk("R6 full", full, q.size() == DEP);
        chk("R6 empty", empty, q.size() == 0);
        acc_w = w && q.size() < DEP;
        acc_r = r && q.size() > 0;
        if (w && !acc_w) exp_ovf = 1;
        wr_valid = w; wr_byte = b; rd_en = r;
        @(posedge clk);
        exp_word = '0;
        if (acc_r) exp_word = q.pop_front();
        if (acc_w) begin
            q.push_back({(wcount % CELL) == 0, b});
            wcount++;
        end
        @(negedge clk);
        wr_valid = 0; rd_en = 0;
        chk("R7 rd_valid", rd_valid, acc_r);
        if (acc_r) begin
            chk("R1 byte", rd_byte, exp_word[7:0]);
            chk("R3 sop", rd_sop, exp_word[8]);
        end
        chk("R4 overflow", overflow, exp_ovf);
        chk("R8 frame_err", frame_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 empty", empty, 1); chk("R9 full", full, 0);
        chk("R9 rd_valid", rd_valid, 0); chk("R9 overflow", overflow, 0);
        // R5: reads on empty queue ignored
        for (int i = 0; i < 3; i++) cyc(0, 0, 1);
        // R2: first byte after reset is marked
        cyc(1, 8'hA5, 0);
        cyc(0, 0, 1);
        chk("R2 first sop", rd_sop, 1);
        // R6/R4: fill to full, then push extra bytes that must be dropped
        for (int i = 0; i < DEP + 3; i++) cyc(1, 8'(i * 7 + 1), 0);
        chk("R4 sticky overflow", overflow, 1);
        // R4: write while full together with read: write still dropped
        cyc(1, 8'hEE, 1);
        // drain fully, then one empty read (R5)
        for (int i = 0; i < DEP + 2; i++) cyc(0, 0, 1);
        // R3: streaming across several cells and queue wraps
        for (int i = 0; i < 4 * CELL + 9; i++) cyc(1, 8'(i ^ 8'h5A), (i % 3) != 0);
        for (int i = 0; i < DEP + 1; i++) cyc(0, 0, 1);
        // R3: burst pattern with fills and drains
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < DEP + 1; i++) cyc(1, 8'(k * 31 + i), 0);
            for (int i = 0; i < DEP + 1; i++) cyc(0, 0, 1);
        end
        chk("R4 overflow still set", overflow, 1);
        // R9: reset clears overflow and restarts marking
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        q.delete(); wcount = 0; exp_ovf = 0;
        chk("R9 overflow cleared", overflow, 0);
        chk("R9 empty after reset", empty, 1);
        cyc(1, 8'h3C, 0);
        cyc(0, 0, 1);
        chk("R2 sop after second reset", rd_sop, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule